// File: doc/BRIEF.md
# Transmit Phase Compensation FIFO

This block passes a parallel data word and its control bits from a user-side write clock domain to a transmit-side read clock domain. Both clocks are expected to run at exactly the same frequency with an arbitrary, fixed phase offset. Data and control travel as one word through one storage entry, so they stay aligned.

A static mode pin picks one of two behaviours, and it is latched while reset is held.

In queue mode the block is an eight-entry asynchronous FIFO. Write and read pointers cross between the domains as Gray code through two-flop synchronizers.

In pass mode the storage is skipped. The output is one register stage in the read domain, so the latency is exactly one read clock cycle.

A frequency mismatch between the clocks eventually shows up in queue mode as a write into a full FIFO or a read from an empty one. Each of these sets a sticky flag.

Each domain has a controller state machine:

- The write controller has states WR_RESET, WR_QUEUE and WR_PASS.
  - Transitions: WR_RESET to WR_QUEUE when the latched mode is 0, and WR_RESET to WR_PASS when it is 1.
  - WR_QUEUE and WR_PASS hold until reset.
- The read controller has states RD_RESET, RD_QUEUE and RD_PASS.
  - Transitions: RD_RESET to RD_QUEUE when the latched mode is 0, and RD_RESET to RD_PASS when it is 1.
  - RD_QUEUE and RD_PASS hold until reset.
- Any reset of a domain returns its controller to its reset state.

Top module: `txpc_fifo`

## Requirements
- R1: In queue mode (bypass_sel latched as 0), words leave in the order they were written, and rd_ctrl stays paired with the rd_data it was written with. Pointer wrap-around does not disturb the order.
- R2: In queue mode the FIFO holds eight words written without any read, and all eight are later read back intact.
- R3: In queue mode, a write pulse while the FIFO is full is dropped and sets overflow. overflow stays 1 until a write-domain reset.
- R4: In queue mode, a read pulse while the FIFO is empty sets underrun and leaves rd_data/rd_ctrl unchanged. underrun stays 1 until a read-domain reset.
- R5: In pass mode (bypass_sel latched as 1), rd_data/rd_ctrl at any read clock cycle equal wr_data/wr_ctrl sampled at the previous rising edge of rd_clk. The latency is exactly one cycle.
- R6: In pass mode, wr_en and rd_en have no effect, and overflow and underrun stay 0.
- R7: bypass_sel is sampled only while reset is held. Changing it after reset release has no effect on behaviour.
- R8: Each domain's reset clears only that domain's pointer and flag. A read-domain reset also drives rd_data and rd_ctrl to 0. After reset both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | User-side write clock |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous assert |
| rd_clk | input | 1 | Transmit parallel (read) clock |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| bypass_sel | input | 1 | Mode select, latched during reset: 0 queue, 1 pass |
| wr_en | input | 1 | Write request (queue mode) |
| wr_data | input | DATA_W | Data word in |
| wr_ctrl | input | CTRL_W | Control bits in |
| rd_en | input | 1 | Read request (queue mode) |
| rd_data | output | DATA_W | Data word out |
| rd_ctrl | output | CTRL_W | Control bits out |
| overflow | output | 1 | Sticky write-while-full flag |
| underrun | output | 1 | Sticky read-while-empty flag |

## Verification
The bench builds the block with its default parameters: 16 data bits, 2 control bits and a 3-bit address, which gives eight entries.

With a depth this small, the full boundary is reached in eight writes and the ninth write is an overflow. The ordering test streams 18 words in batches, so both Gray pointers wrap past their top count.

The two clocks share one period with a 3 ns phase offset. This exercises the synchronizer path in queue mode and the one-cycle capture in pass mode.

// File: rtl/txpc_pkg.sv
package txpc_pkg;
    typedef enum logic [1:0] {
        WR_RESET = 2'd0,
        WR_QUEUE = 2'd1,
        WR_PASS  = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_RESET = 2'd0,
        RD_QUEUE = 2'd1,
        RD_PASS  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/txpc_rst_sync.sv
module txpc_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= 1'b0;
            srst_n <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            srst_n <= stage1;
        end
    end
endmodule

// File: rtl/txpc_gray_sync.sv
module txpc_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/txpc_wr_ctrl.sv
module txpc_wr_ctrl
    import txpc_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_pin,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          overflow
);
    wr_state_e   state, next;
    logic        mode_q;
    logic [AW:0] wbin, wbin_inc;
    logic        full, ovf_hit;

    // State register; the mode pin is tracked only while reset holds.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= WR_RESET;
            mode_q <= mode_pin;
        end else begin
            state  <= next;
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            WR_RESET: next = mode_q ? WR_PASS : WR_QUEUE;
            WR_QUEUE: next = WR_QUEUE;
            WR_PASS:  next = WR_PASS;
            default:  next = WR_RESET;
        endcase
    end

    // Outputs and decode
    always_comb begin
        wbin_inc = wbin + 1'b1;
        full     = (wgray == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
        push     = (state == WR_QUEUE) && wr_en && !full;
        ovf_hit  = (state == WR_QUEUE) && wr_en && full;
        waddr    = wbin[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) begin
                wbin  <= wbin_inc;
                wgray <= (wbin_inc >> 1) ^ wbin_inc;
            end
            if (ovf_hit) overflow <= 1'b1;
        end
    end

    AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R1
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R3
    AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(wr_en)); // R3
    AST_WR_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WR_RESET) |=> $stable(state)); // R7
endmodule

// File: rtl/txpc_rd_ctrl.sv
module txpc_rd_ctrl
    import txpc_pkg::*;
#(
    parameter int AW = 3,
    parameter int WW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_pin,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [WW-1:0] mem_word,
    input  logic [WW-1:0] pass_word,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [WW-1:0] rd_word,
    output logic          underrun
);
    rd_state_e   state, next;
    logic        mode_q;
    logic [AW:0] rbin, rbin_inc;
    logic        empty, pop, starve;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RD_RESET;
            mode_q <= mode_pin;
        end else begin
            state  <= next;
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            RD_RESET: next = mode_q ? RD_PASS : RD_QUEUE;
            RD_QUEUE: next = RD_QUEUE;
            RD_PASS:  next = RD_PASS;
            default:  next = RD_RESET;
        endcase
    end

    always_comb begin
        rbin_inc = rbin + 1'b1;
        empty    = (rgray == wgray_sync);
        pop      = (state == RD_QUEUE) && rd_en && !empty;
        starve   = (state == RD_QUEUE) && rd_en && empty;
        raddr    = rbin[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            rd_word  <= '0;
            underrun <= 1'b0;
        end else begin
            if (state == RD_PASS) begin
                rd_word <= pass_word;
            end else if (pop) begin
                rd_word <= mem_word;
                rbin    <= rbin_inc;
                rgray   <= (rbin_inc >> 1) ^ rbin_inc;
            end
            if (starve) underrun <= 1'b1;
        end
    end

    AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R1
    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_QUEUE && rd_en && empty) |=> $stable(rd_word)); // R4
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R4
    AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_PASS) |=> (rd_word == $past(pass_word))); // R5
    AST_PASS_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_PASS) |-> !underrun); // R6
    AST_RD_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RD_RESET) |=> $stable(state)); // R7
endmodule

// File: rtl/txpc_fifo.sv
module txpc_fifo #(
    parameter int DATA_W = 16,
    parameter int CTRL_W = 2,
    parameter int ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              bypass_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTRL_W-1:0] rd_ctrl,
    output logic              overflow,
    output logic              underrun
);
    localparam int WW    = DATA_W + CTRL_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic              wr_srst_n, rd_srst_n;
    logic              push;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [ADDR_W:0]   wgray, rgray, wgray_rd, rgray_wr;
    logic [WW-1:0]     in_word, mem_word, out_word;
    logic [WW-1:0]     mem [DEPTH];

    assign in_word = {wr_ctrl, wr_data};

    txpc_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_rst_n), .srst_n(wr_srst_n));
    txpc_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_rst_n), .srst_n(rd_srst_n));

    txpc_gray_sync #(.W(ADDR_W + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rd_srst_n), .d(wgray), .q(wgray_rd));
    txpc_gray_sync #(.W(ADDR_W + 1)) u_r2w (
        .clk(wr_clk), .rst_n(wr_srst_n), .d(rgray), .q(rgray_wr));

    txpc_wr_ctrl #(.AW(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_srst_n), .mode_pin(bypass_sel), .wr_en(wr_en),
        .rgray_sync(rgray_wr), .push(push), .waddr(waddr), .wgray(wgray),
        .overflow(overflow));

    always_ff @(posedge wr_clk) begin
        if (push) mem[waddr] <= in_word;
    end

    assign mem_word = mem[raddr];

    txpc_rd_ctrl #(.AW(ADDR_W), .WW(WW)) u_rd (
        .clk(rd_clk), .rst_n(rd_srst_n), .mode_pin(bypass_sel), .rd_en(rd_en),
        .wgray_sync(wgray_rd), .mem_word(mem_word), .pass_word(in_word),
        .raddr(raddr), .rgray(rgray), .rd_word(out_word), .underrun(underrun));

    assign rd_data = out_word[DATA_W-1:0];
    assign rd_ctrl = out_word[WW-1:DATA_W];
endmodule

// File: tb/txpc_fifo_test.sv
module txpc_fifo_test;
    localparam int DW = 16;
    localparam int CW = 2;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          bypass_sel = 0, wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] wr_ctrl = '0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] rd_ctrl;
    logic          overflow, underrun;
    int            checks = 0, errors = 0;

    txpc_fifo uut (.*);

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] pattern(int i);
        return {i[1:0], 16'hA000 + 16'(i * 16'h0111)};
    endfunction

    task automatic do_reset(logic mode);
        bypass_sel = mode;
        wr_en = 0;
        rd_en = 0;
        wr_rst_n = 0;
        rd_rst_n = 0;
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1;
        rd_rst_n = 1;
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic write_word(logic [17:0] w);
        @(negedge wr_clk);
        wr_en = 1;
        {wr_ctrl, wr_data} = w;
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic read_word(output logic [17:0] w);
        @(negedge rd_clk);
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        w = {rd_ctrl, rd_data};
    endtask

    task automatic test_reset_state();
        do_reset(0);
        check("R8 rd_data after reset", 32'(rd_data), 0);
        check("R8 rd_ctrl after reset", 32'(rd_ctrl), 0);
        check("R8 overflow after reset", 32'(overflow), 0);
        check("R8 underrun after reset", 32'(underrun), 0);
    endtask

    task automatic test_order();
        logic [17:0] got;
        int idx = 0;
        do_reset(0);
        for (int round = 0; round < 3; round++) begin
            for (int k = 0; k < 6; k++) write_word(pattern(idx + k));
            repeat (5) @(negedge rd_clk);
            for (int k = 0; k < 6; k++) begin
                read_word(got);
                check("R1 order and ctrl pairing", 32'(got), 32'(pattern(idx + k)));
            end
            idx += 6;
        end
        check("R1 no overflow", 32'(overflow), 0);
        check("R1 no underrun", 32'(underrun), 0);
    endtask

    task automatic test_full_and_flags();
        logic [17:0] got;
        do_reset(0);
        for (int k = 0; k < 8; k++) write_word(pattern(40 + k));
        check("R2 eight writes no overflow", 32'(overflow), 0);
        write_word(18'h3BEEF);
        check("R3 overflow on ninth write", 32'(overflow), 1);
        repeat (5) @(negedge rd_clk);
        for (int k = 0; k < 8; k++) begin
            read_word(got);
            check("R2 stored word intact", 32'(got), 32'(pattern(40 + k)));
        end
        check("R3 overflow sticky", 32'(overflow), 1);
        read_word(got);
        check("R3 dropped word not stored / R4 output held", 32'(got), 32'(pattern(47)));
        check("R4 underrun set", 32'(underrun), 1);
        repeat (3) @(negedge rd_clk);
        check("R4 underrun sticky", 32'(underrun), 1);
        @(negedge wr_clk);
        wr_rst_n = 0;
        repeat (2) @(negedge wr_clk);
        wr_rst_n = 1;
        repeat (3) @(negedge wr_clk);
        check("R8 write reset clears overflow", 32'(overflow), 0);
        check("R8 write reset keeps underrun", 32'(underrun), 1);
        @(negedge rd_clk);
        rd_rst_n = 0;
        repeat (2) @(negedge rd_clk);
        check("R8 read reset clears underrun", 32'(underrun), 0);
        check("R8 read reset zeroes rd_data", 32'(rd_data), 0);
        rd_rst_n = 1;
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic test_mode_freeze_queue();
        logic [17:0] got;
        do_reset(0);
        write_word(pattern(60));
        repeat (5) @(negedge rd_clk);
        read_word(got);
        check("R7 queue read before pin change", 32'(got), 32'(pattern(60)));
        bypass_sel = 1;
        @(negedge rd_clk);
        {wr_ctrl, wr_data} = 18'h1CAFE;
        repeat (4) @(negedge rd_clk);
        check("R7 pin change does not enable pass", 32'({rd_ctrl, rd_data}), 32'(pattern(60)));
        write_word(pattern(61));
        repeat (5) @(negedge rd_clk);
        read_word(got);
        check("R7 queue still works", 32'(got), 32'(pattern(61)));
    endtask

    task automatic test_pass();
        logic [17:0] prev;
        do_reset(1);
        bypass_sel = 0;
        prev = {wr_ctrl, wr_data};
        for (int k = 0; k < 5; k++) begin
            @(negedge rd_clk);
            {wr_ctrl, wr_data} = pattern(80 + k);
            #1;
            check("R5 output not yet updated", 32'({rd_ctrl, rd_data}), 32'(prev));
            @(negedge rd_clk);
            check("R5 one-cycle pass latency", 32'({rd_ctrl, rd_data}), 32'(pattern(80 + k)));
            prev = pattern(80 + k);
        end
        check("R7 pass mode kept after pin cleared", 32'({rd_ctrl, rd_data}), 32'(pattern(84)));
        wr_en = 1;
        rd_en = 1;
        repeat (20) @(negedge rd_clk);
        wr_en = 0;
        rd_en = 0;
        @(negedge rd_clk);
        check("R6 overflow stays 0 in pass", 32'(overflow), 0);
        check("R6 underrun stays 0 in pass", 32'(underrun), 0);
        check("R6 enables do not alter output", 32'({rd_ctrl, rd_data}), 32'(pattern(84)));
    endtask

    initial begin
        test_reset_state();
        test_order();
        test_full_and_flags();
        test_mode_freeze_queue();
        test_pass();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule